// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame sync for a serial audio port. It counts bit clocks, which arrive as a one-cycle `bclk_tick` pulse in the system clock domain. Two run modes exist. In internal mode the block builds a periodic frame sync from a programmed frame length and pulse width. In external mode it passes through a frame sync from a pin. When the bit clock itself comes from a pin and the frame sync is still generated here, the block runs in internal mode: the source of `bclk_tick` makes no difference to it. The transmit and receive sides each get their own copy of the frame sync, and each copy has its own polarity. A frame-start strobe marks the first bit clock of every frame so that the data shifters can align to it.

Both the frame length and the pulse width are programmed as the count minus one. For example, 16-bit stereo uses a frame length field of 31 and a width field of 15, which gives a 50% duty frame clock.

Two gates control start-up and shut-down:
- `gen_run` releases the generator.
- `fs_run` releases the frame-sync output.

Software releases the generator first, then enables its shifters, then releases frame sync. To stop, it drops both gates together.

A four-state controller sequences this:
- **IDLE**: the generator is held in reset.
- **ARMED**: the generator is released, but the frame sync is held inactive.
- **RUN**: frames are counted.
- **HALT**: the single frame of non-periodic mode has finished.

The transitions are:
- IDLE→ARMED when `gen_run` is high.
- ARMED→RUN on a bit clock tick while `fs_run` is high.
- RUN→HALT at the end of a frame in internal non-periodic mode.
- RUN→ARMED or HALT→ARMED when `fs_run` falls.
- Any state →IDLE when `gen_run` falls.

Top module: `fsync_gen`

## Requirements
- R1: While `gen_run`=0, the following hold whatever `fs_run` and `bclk_tick` do: `frame_start`=0, `fs_tx`=`fs_pol_tx`, `fs_rx`=`fs_pol_rx` (the inactive level), and the bit counter stays at zero.
- R2: After `gen_run` rises, the outputs stay inactive until `fs_run` is high and a `bclk_tick` arrives. The bit clock after that tick is frame bit 0.
- R3: In internal mode a frame lasts `period_m1`+1 bit clocks. `frame_start` is 1 during bit 0 of each frame and 0 otherwise.
- R4: In internal mode the sync is active during bits 0 to `width_m1` of each frame. A `width_m1` at or above `period_m1` keeps it active for the whole frame.
- R5: Each output equals the active state XOR its polarity bit: polarity 0 means active high and 1 means active low. `fs_tx` and `fs_rx` take their polarity independently.
- R6: In internal mode with `periodic_en`=0, exactly one frame is produced. After it the outputs stay inactive until `fs_run` is dropped and raised again.
- R7: With `gen_run`=1 and `fs_run`=0, the outputs are inactive. Re-raising `fs_run` restarts the frame at bit 0 on the next tick.
- R8: In external mode (`fs_internal`=0), while running, the sync is active exactly when `ext_fs` is 1. `frame_start` is 1 in a bit clock where `ext_fs` is 1 and was 0 in the previous bit clock. `periodic_en` has no effect in this mode.
- R9: Dropping `gen_run` and `fs_run` in the same cycle makes all outputs inactive one clock later.
- R10: The frame position advances only on `bclk_tick`. Without ticks, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_tick | input | 1 | One-cycle pulse per bit clock |
| gen_run | input | 1 | Generator release (0 holds it in reset) |
| fs_run | input | 1 | Frame-sync release (0 suppresses the sync) |
| period_m1 | input | PW | Bit clocks per frame minus one |
| width_m1 | input | PW | Active sync width in bit clocks minus one |
| fs_pol_tx | input | 1 | Transmit sync polarity, 1 = active low |
| fs_pol_rx | input | 1 | Receive sync polarity, 1 = active low |
| periodic_en | input | 1 | 1 = repeat frames, 0 = a single frame |
| fs_internal | input | 1 | 1 = generate internally, 0 = take `ext_fs` |
| ext_fs | input | 1 | External frame sync, active high |
| fs_tx | output | 1 | Transmit-side frame sync |
| fs_rx | output | 1 | Receive-side frame sync |
| frame_start | output | 1 | High during the first bit clock of a frame |

## Verification
The hardest situations to reach are the edges of the frame counter:
- the wrap at every programmed frame length;
- a width field equal to or above the period;
- the single-frame stop.

Each of these only shows after many ticks with the right pair of fields. The bench therefore sweeps every period from 1 to 7, every width from 0 to the period, and all four polarity pairs. For each combination it runs past two wraps and predicts each bit clock from the bit index modulo the frame length.

Release ordering is driven explicitly: `fs_run` is raised before `gen_run`, and `fs_run` is dropped mid-frame. A tick-free gap mid-frame shows that the frame position holds between ticks.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } fsg_state_e;

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_run,
    input  logic       fs_run,
    input  logic       bclk_tick,
    input  logic       wrap,
    input  logic       oneshot,
    output fsg_state_e st_q,
    output fsg_state_e st_d
);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (gen_run) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!gen_run)                  st_d = ST_IDLE;
                else if (fs_run && bclk_tick)  st_d = ST_RUN;
            end
            ST_RUN: begin
                if (!gen_run)                  st_d = ST_IDLE;
                else if (!fs_run)              st_d = ST_ARMED;
                else if (wrap && oneshot)      st_d = ST_HALT;
            end
            ST_HALT: begin
                if (!gen_run)                  st_d = ST_IDLE;
                else if (!fs_run)              st_d = ST_ARMED;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fsg_counter.sv
module fsg_counter #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_now,
    input  logic          run_next,
    input  logic          bclk_tick,
    input  logic [PW-1:0] period_m1,
    output logic [PW-1:0] cnt_q,
    output logic          wrap
);

    // Last bit of a frame; >= guards against a period shortened mid-frame
    assign wrap = run_now && bclk_tick && (cnt_q >= period_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_next) begin
            cnt_q <= '0;
        end else if (run_now && bclk_tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fsg_outmux.sv
module fsg_outmux
    import fsg_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_tick,
    input  fsg_state_e    st_q,
    input  logic [PW-1:0] cnt_q,
    input  logic [PW-1:0] width_m1,
    input  logic          fs_internal,
    input  logic          ext_fs,
    input  logic          fs_pol_tx,
    input  logic          fs_pol_rx,
    output logic          fs_tx,
    output logic          fs_rx,
    output logic          frame_start
);

    logic ext_prev_q;
    logic running;
    logic active;

    // External sync level seen in the previous bit clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ext_prev_q <= 1'b0;
        else if (bclk_tick) ext_prev_q <= ext_fs;
    end

    assign running = (st_q == ST_RUN);

    always_comb begin
        active      = 1'b0;
        frame_start = 1'b0;
        if (running) begin
            if (fs_internal) begin
                active      = (cnt_q <= width_m1);
                frame_start = (cnt_q == '0);
            end else begin
                active      = ext_fs;
                frame_start = ext_fs && !ext_prev_q;
            end
        end
        fs_tx = active ^ fs_pol_tx;
        fs_rx = active ^ fs_pol_rx;
    end

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
    import fsg_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_tick,
    input  logic          gen_run,
    input  logic          fs_run,
    input  logic [PW-1:0] period_m1,
    input  logic [PW-1:0] width_m1,
    input  logic          fs_pol_tx,
    input  logic          fs_pol_rx,
    input  logic          periodic_en,
    input  logic          fs_internal,
    input  logic          ext_fs,
    output logic          fs_tx,
    output logic          fs_rx,
    output logic          frame_start
);

    fsg_state_e    st_q;
    fsg_state_e    st_d;
    logic [PW-1:0] cnt_q;
    logic          wrap;
    logic          oneshot;

    assign oneshot = fs_internal && !periodic_en;

    fsg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_run   (gen_run),
        .fs_run    (fs_run),
        .bclk_tick (bclk_tick),
        .wrap      (wrap),
        .oneshot   (oneshot),
        .st_q      (st_q),
        .st_d      (st_d)
    );

    fsg_counter #(.PW(PW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_now   (st_q == ST_RUN),
        .run_next  (st_d == ST_RUN),
        .bclk_tick (bclk_tick),
        .period_m1 (period_m1),
        .cnt_q     (cnt_q),
        .wrap      (wrap)
    );

    fsg_outmux #(.PW(PW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_tick   (bclk_tick),
        .st_q        (st_q),
        .cnt_q       (cnt_q),
        .width_m1    (width_m1),
        .fs_internal (fs_internal),
        .ext_fs      (ext_fs),
        .fs_pol_tx   (fs_pol_tx),
        .fs_pol_rx   (fs_pol_rx),
        .fs_tx       (fs_tx),
        .fs_rx       (fs_rx),
        .frame_start (frame_start)
    );

endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk
    import fsg_pkg::*;
#(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bclk_tick,
    input logic          gen_run,
    input logic          fs_run,
    input logic [PW-1:0] period_m1,
    input logic          fs_pol_tx,
    input logic          fs_pol_rx,
    input logic          fs_tx,
    input logic          fs_rx,
    input logic          frame_start,
    input fsg_state_e    state,
    input logic [PW-1:0] cnt
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_run && $past(!gen_run)) |->
            (fs_tx == fs_pol_tx && fs_rx == fs_pol_rx && !frame_start));

    // R7
    fsreset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_run && $past(!fs_run)) |->
            (fs_tx == fs_pol_tx && fs_rx == fs_pol_rx && !frame_start));

    // R3
    strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (fs_tx != fs_pol_tx));

    // R5
    sides_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fs_tx ^ fs_pol_tx) == (fs_rx ^ fs_pol_rx)));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !bclk_tick) |=>
            (state != ST_RUN || cnt == $past(cnt)));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && bclk_tick && cnt >= period_m1) |=> (cnt == '0));

    // R1
    count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (cnt == '0));

endmodule

bind fsync_gen fsync_gen_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_tick   (bclk_tick),
    .gen_run     (gen_run),
    .fs_run      (fs_run),
    .period_m1   (period_m1),
    .fs_pol_tx   (fs_pol_tx),
    .fs_pol_rx   (fs_pol_rx),
    .fs_tx       (fs_tx),
    .fs_rx       (fs_rx),
    .frame_start (frame_start),
    .state       (st_q),
    .cnt         (cnt_q)
);

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;

    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk_tick = 1'b0;
    logic          gen_run = 1'b0;
    logic          fs_run = 1'b0;
    logic [PW-1:0] period_m1 = '0;
    logic [PW-1:0] width_m1 = '0;
    logic          fs_pol_tx = 1'b0;
    logic          fs_pol_rx = 1'b0;
    logic          periodic_en = 1'b1;
    logic          fs_internal = 1'b1;
    logic          ext_fs = 1'b0;
    logic          fs_tx;
    logic          fs_rx;
    logic          frame_start;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fsync_gen #(.PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
        .gen_run(gen_run), .fs_run(fs_run),
        .period_m1(period_m1), .width_m1(width_m1),
        .fs_pol_tx(fs_pol_tx), .fs_pol_rx(fs_pol_rx),
        .periodic_en(periodic_en), .fs_internal(fs_internal),
        .ext_fs(ext_fs), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .frame_start(frame_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare outputs against an expected active state and strobe
    task automatic check_out(input string req, input bit act, input bit fst);
        check({req, " fs_tx"}, 32'(fs_tx), 32'(act ^ fs_pol_tx));
        check({req, " fs_rx"}, 32'(fs_rx), 32'(act ^ fs_pol_rx));
        check({req, " frame_start"}, 32'(frame_start), 32'(fst));
    endtask

    // Called at a negedge; returns at a negedge one bit clock later
    task automatic do_tick();
        bclk_tick = 1'b1;
        @(negedge clk);
        bclk_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start_run();
        gen_run = 1'b1;
        @(negedge clk);
        check_out("R2 armed", 1'b0, 1'b0);
        fs_run = 1'b1;
        @(negedge clk);
        check_out("R2 wait tick", 1'b0, 1'b0);
        do_tick();
    endtask

    task automatic stop_both();
        gen_run = 1'b0;
        fs_run  = 1'b0;
        @(negedge clk);
        check_out("R9 stop", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 1'b0, 1'b0);

        // R1: fs_run released first has no effect while the generator is held
        period_m1 = 8'd3; width_m1 = 8'd1;
        fs_run = 1'b1;
        for (int i = 0; i < 3; i++) begin
            do_tick();
            check_out("R1 fs first", 1'b0, 1'b0);
        end
        gen_run = 1'b1;
        @(negedge clk);
        check_out("R2 armed with fs", 1'b0, 1'b0);
        do_tick();
        check_out("R2 bit0", 1'b1, 1'b1);
        stop_both();

        // R3 R4 R5: sweep periods, widths and polarity pairs
        for (int p = 1; p <= 7; p++) begin
            for (int w = 0; w <= p; w++) begin
                for (int pol = 0; pol < 4; pol++) begin
                    period_m1 = 8'(p);
                    width_m1  = 8'(w);
                    fs_pol_tx = pol[0];
                    fs_pol_rx = pol[1];
                    start_run();
                    for (int k = 0; k < 2 * (p + 1) + 2; k++) begin
                        int m;
                        m = k % (p + 1);
                        check("R4 fs_tx", 32'(fs_tx), 32'((m <= w) ^ fs_pol_tx));
                        check("R5 fs_rx", 32'(fs_rx), 32'((m <= w) ^ fs_pol_rx));
                        check("R3 frame_start", 32'(frame_start), 32'(m == 0));
                        do_tick();
                    end
                    stop_both();
                end
            end
        end
        fs_pol_tx = 1'b0;
        fs_pol_rx = 1'b1;

        // R4 width beyond period keeps sync active
        period_m1 = 8'd3; width_m1 = 8'd9;
        start_run();
        for (int k = 0; k < 8; k++) begin
            check_out("R4 wide", 1'b1, (k % 4) == 0);
            do_tick();
        end
        stop_both();

        // R10 + standard 16-bit stereo framing (31/15)
        period_m1 = 8'd31; width_m1 = 8'd15;
        start_run();
        for (int k = 0; k < 70; k++) begin
            int m;
            m = k % 32;
            check_out("R3 stereo", m <= 15, m == 0);
            if (k == 5 || k == 32) begin
                repeat (10) @(negedge clk);
                check_out("R10 no tick hold", m <= 15, m == 0);
            end
            do_tick();
        end

        // R7: frame-sync reset alone, then restart at bit 0
        fs_run = 1'b0;
        @(negedge clk);
        check_out("R7 fs reset", 1'b0, 1'b0);
        do_tick();
        check_out("R7 fs reset tick", 1'b0, 1'b0);
        fs_run = 1'b1;
        @(negedge clk);
        check_out("R7 wait tick", 1'b0, 1'b0);
        do_tick();
        for (int k = 0; k < 34; k++) begin
            check_out("R7 restart", (k % 32) <= 15, (k % 32) == 0);
            do_tick();
        end
        stop_both();

        // R6: single frame when periodic mode is off
        periodic_en = 1'b0;
        period_m1 = 8'd5; width_m1 = 8'd2;
        start_run();
        for (int k = 0; k < 18; k++) begin
            check_out("R6 oneshot", (k <= 5) && (k <= 2), k == 0);
            do_tick();
        end
        fs_run = 1'b0;
        @(negedge clk);
        fs_run = 1'b1;
        @(negedge clk);
        do_tick();
        check_out("R6 re-release", 1'b1, 1'b1);
        stop_both();

        // R8: external sync pass-through, periodic_en left at 0 (ignored)
        fs_internal = 1'b1;
        fs_internal = 1'b0;
        ext_fs = 1'b1;
        gen_run = 1'b1;
        @(negedge clk);
        check_out("R8 armed ext high", 1'b0, 1'b0);
        ext_fs = 1'b0;
        start_run();
        for (int k = 0; k < 30; k++) begin
            bit cur;
            bit prv;
            cur = ((k % 7) < 3) && (k != 15);
            prv = (k == 0) ? 1'b0 : (((k - 1) % 7) < 3) && (k - 1 != 15);
            ext_fs = cur;
            #1;
            check_out("R8 ext", cur, cur && !prv);
            do_tick();
        end
        fs_run = 1'b0;
        ext_fs = 1'b1;
        @(negedge clk);
        check_out("R8 ext suppressed", 1'b0, 1'b0);
        stop_both();
        do_tick();
        check_out("R1 idle end", 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule